// File: doc/BRIEF.md
# SPI Master with Per-Word Frame Control

This block is the serial engine of an SPI master. It pulls words from a transmit queue through a valid/ready handshake and shifts each one out on MOSI, MSB first, with a word length between 1 and 16 bits. The bits it samples on MISO go to a receive queue as a single-cycle valid pulse. Clock polarity, clock phase, word length, a prescaler, a rate divider and a chip-select index are live configuration inputs. The engine drives SCK and eight active-low chip selects.

The block has two framing modes. In plain mode, every word gets its own chip-select assertion. In frame-control mode, bits 31 and 30 of each transmit entry decide when the chip select is released. An entry with the end flag closes the frame after its data has been shifted. An entry with both the end flag and the drop flag closes the frame without moving any data. Each received word carries a marker bit that shows whether it was the first word of its frame.

Top module: `spi_blk_master`

## Requirements
- R1: The word length is `wsize_i + 1` bits (code 0 = 1 bit, 3 = 4, 7 = 8, 15 = 16). Transmit data comes from `tx_data_i[wsize_i:0]` and is sent MSB first. The received bits arrive right-aligned in `rx_data_o[15:0]`, with bits 30:16 at zero, and `rx_valid_o` pulses for exactly one cycle per word.
- R2: While idle, `sck_o` rests at `cpol_i`. With `cpha_i`=0, MISO is sampled on the leading (first) edge of each bit. With `cpha_i`=1, it is sampled on the trailing edge. The transmitted bit is stable at the sampling edge in both cases.
- R3: Every SCK half period, including the delay from chip select falling to the first edge and from the last edge to chip select rising, lasts `D*(scr_i+1)` clocks. D is `presc_i` with bit 0 forced to zero, and a result of 0 counts as 1.
- R4: Only `cs_no[cs_idx_i]` is driven low during a frame. At most one chip select is ever low.
- R5: With `blk_mode_i`=0, the chip select asserts before each word and is released after it, and `rx_data_o[31]` is 0.
- R6: With `blk_mode_i`=1, the chip select stays low across consecutive words. It is released only after a word with `tx_data_i[31]` (end flag) set has been shifted out.
- R7: With `blk_mode_i`=1, an entry with both `tx_data_i[31]` and `tx_data_i[30]` (drop flag) set closes an open frame in the accepting cycle. It causes no SCK edge and no received word, and it has no effect when no frame is open. The drop flag alone is ignored, and the word is shifted as normal data.
- R8: With `blk_mode_i`=1, `rx_data_o[31]` is 1 only for the first word received after the chip select went low.
- R9: `busy_o` is high from the acceptance of a data-carrying entry until its received word is delivered. `tx_ready_o` is high only while not busy. The chip select does not change while busy stays high.
- R10: After reset, all chip selects are high, `busy_o` and `rx_valid_o` are low, `tx_ready_o` is high and `sck_o` equals `cpol_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpol_i | input | 1 | SCK idle level |
| cpha_i | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| wsize_i | input | 4 | Word length minus one |
| presc_i | input | 8 | Prescaler, bit 0 ignored, 0 acts as 1 |
| scr_i | input | 8 | Rate divider, half period multiplier minus one |
| cs_idx_i | input | 3 | Chip select index |
| blk_mode_i | input | 1 | Frame-control mode enable |
| tx_valid_i | input | 1 | Transmit entry available |
| tx_data_i | input | 32 | [31] end flag, [30] drop flag, [15:0] data |
| tx_ready_o | output | 1 | Entry accepted when high with tx_valid_i |
| rx_valid_o | output | 1 | One-cycle pulse with a received word |
| rx_data_o | output | 32 | [31] first-in-frame marker, [15:0] data |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_no | output | 8 | Chip selects, active low |
| busy_o | output | 1 | Transfer in progress |

## Verification
A frame-closing entry can be accepted in the same cycle as the delivery of the previous word's result. The bench provokes this by queuing an end-and-drop entry right behind a data word in frame-control mode. It judges the outcome at the ports: the received-word count rises by exactly one, the SCK edge count does not move after that word, the chip select is high on the next sample, and the slave model saw the full word. A second collision happens at the end of each word, where the chip-select release and the final received word share one clock edge. The bench checks that the received data and the first-word marker are intact, and that exactly one chip-select rising edge is counted for each frame.

// File: rtl/spi_blk_pkg.sv
`timescale 1ns/1ps
package spi_blk_pkg;
  localparam int END_BIT   = 31;
  localparam int DROP_BIT  = 30;
  localparam int FIRST_BIT = 31;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_HOLD = 2'd2
  } spi_state_e;
endpackage

// File: rtl/spi_blk_clkgen.sv
`timescale 1ns/1ps
module spi_blk_clkgen #(
  parameter int PRESC_W = 8,
  parameter int SCR_W   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic [PRESC_W-1:0] presc_i,
  input  logic [SCR_W-1:0]   scr_i,
  output logic               tick_o
);
  localparam int CNT_W = PRESC_W + SCR_W + 1;

  logic [PRESC_W-1:0] div;
  logic [SCR_W:0]     scr_p1;
  logic [CNT_W-1:0]   half;
  logic [CNT_W-1:0]   cnt_q;

  always_comb begin
    div = {presc_i[PRESC_W-1:1], 1'b0};
    if (div == '0) div = PRESC_W'(1);
    scr_p1 = {1'b0, scr_i} + 1'b1;
    half   = CNT_W'(div) * CNT_W'(scr_p1);
  end

  assign tick_o = run_i && (cnt_q == half - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_blk_shifter.sv
`timescale 1ns/1ps
module spi_blk_shifter #(
  parameter int DATA_W = 16,
  localparam int WS_W  = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic [WS_W-1:0]   wsize_i,
  input  logic              shift_i,
  input  logic              sample_i,
  input  logic              miso_i,
  output logic              mosi_o,
  output logic [DATA_W-1:0] rx_o
);
  localparam logic [WS_W-1:0] TOP = WS_W'(DATA_W - 1);

  logic [DATA_W-1:0] tx_sr, rx_sr;
  logic [WS_W-1:0]   amt;

  assign amt    = TOP - wsize_i;
  assign mosi_o = tx_sr[DATA_W-1];
  assign rx_o   = rx_sr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sr <= '0;
      rx_sr <= '0;
    end else if (load_i) begin
      tx_sr <= load_data_i << amt; // MSB of the word at the top
      rx_sr <= '0;
    end else begin
      if (shift_i)  tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
      if (sample_i) rx_sr <= {rx_sr[DATA_W-2:0], miso_i};
    end
  end
endmodule

// File: rtl/spi_blk_csdec.sv
`timescale 1ns/1ps
module spi_blk_csdec #(
  parameter int NCS    = 8,
  localparam int IDX_W = $clog2(NCS)
) (
  input  logic             active_i,
  input  logic [IDX_W-1:0] sel_i,
  output logic [NCS-1:0]   cs_no
);
  for (genvar g = 0; g < NCS; g++) begin : g_cs
    assign cs_no[g] = !(active_i && (sel_i == IDX_W'(g)));
  end
endmodule

// File: rtl/spi_blk_master.sv
`timescale 1ns/1ps
module spi_blk_master
  import spi_blk_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int WORD_W  = 32,
  parameter int NCS     = 8,
  parameter int PRESC_W = 8,
  parameter int SCR_W   = 8,
  localparam int WS_W   = $clog2(DATA_W),
  localparam int IDX_W  = $clog2(NCS),
  localparam int EC_W   = WS_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cpol_i,
  input  logic               cpha_i,
  input  logic [WS_W-1:0]    wsize_i,
  input  logic [PRESC_W-1:0] presc_i,
  input  logic [SCR_W-1:0]   scr_i,
  input  logic [IDX_W-1:0]   cs_idx_i,
  input  logic               blk_mode_i,
  input  logic               tx_valid_i,
  input  logic [WORD_W-1:0]  tx_data_i,
  output logic               tx_ready_o,
  output logic               rx_valid_o,
  output logic [WORD_W-1:0]  rx_data_o,
  output logic               sck_o,
  output logic               mosi_o,
  input  logic               miso_i,
  output logic [NCS-1:0]     cs_no,
  output logic               busy_o
);
  spi_state_e        state_q;
  logic [EC_W-1:0]   edge_q;
  logic [WS_W-1:0]   wsize_q;
  logic [IDX_W-1:0]  cs_sel_q;
  logic              sck_q, cs_act_q, first_q, end_q;
  logic              rx_valid_q;
  logic [WORD_W-1:0] rx_data_q;

  logic tick, accept, close_only, load, even, last_edge, do_shift, do_sample;
  logic [DATA_W-1:0] rx_bits;

  assign accept     = (state_q == ST_IDLE) && tx_valid_i;
  assign close_only = blk_mode_i && tx_data_i[END_BIT] && tx_data_i[DROP_BIT];
  assign load       = accept && !close_only;
  assign even       = !edge_q[0];
  assign last_edge  = (edge_q == {wsize_q, 1'b1});

  // leading edges are the even ones
  always_comb begin
    do_shift  = 1'b0;
    do_sample = 1'b0;
    if (state_q == ST_XFER && tick) begin
      if (cpha_i) begin
        do_sample = !even;
        do_shift  = even && (edge_q != '0);
      end else begin
        do_sample = even;
        do_shift  = !even && !last_edge;
      end
    end
  end

  spi_blk_clkgen #(.PRESC_W(PRESC_W), .SCR_W(SCR_W)) u_clkgen (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (state_q != ST_IDLE),
    .presc_i (presc_i),
    .scr_i   (scr_i),
    .tick_o  (tick)
  );

  spi_blk_shifter #(.DATA_W(DATA_W)) u_shifter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .load_data_i (tx_data_i[DATA_W-1:0]),
    .wsize_i     (wsize_i),
    .shift_i     (do_shift),
    .sample_i    (do_sample),
    .miso_i      (miso_i),
    .mosi_o      (mosi_o),
    .rx_o        (rx_bits)
  );

  spi_blk_csdec #(.NCS(NCS)) u_csdec (
    .active_i (cs_act_q),
    .sel_i    (cs_sel_q),
    .cs_no    (cs_no)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      edge_q     <= '0;
      wsize_q    <= '0;
      cs_sel_q   <= '0;
      sck_q      <= 1'b0;
      cs_act_q   <= 1'b0;
      first_q    <= 1'b0;
      end_q      <= 1'b0;
      rx_valid_q <= 1'b0;
      rx_data_q  <= '0;
    end else begin
      rx_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept && close_only) begin
            cs_act_q <= 1'b0;
          end else if (load) begin
            cs_act_q <= 1'b1;
            if (!cs_act_q) cs_sel_q <= cs_idx_i;
            first_q  <= !cs_act_q;
            end_q    <= tx_data_i[END_BIT];
            wsize_q  <= wsize_i;
            edge_q   <= '0;
            sck_q    <= 1'b0;
            state_q  <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (tick) begin
            sck_q  <= !sck_q;
            edge_q <= edge_q + 1'b1;
            if (last_edge) state_q <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (tick) begin
            rx_valid_q <= 1'b1;
            rx_data_q  <= {first_q && blk_mode_i,
                           {(WORD_W-1-DATA_W){1'b0}}, rx_bits};
            first_q    <= 1'b0;
            if (!blk_mode_i || end_q) cs_act_q <= 1'b0;
            state_q    <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sck_o      = sck_q ^ cpol_i;
  assign busy_o     = (state_q != ST_IDLE);
  assign tx_ready_o = (state_q == ST_IDLE);
  assign rx_valid_o = rx_valid_q;
  assign rx_data_o  = rx_data_q;
endmodule

// File: rtl/spi_blk_master_chk.sv
`timescale 1ns/1ps
module spi_blk_master_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cpol_i,
  input logic        blk_mode_i,
  input logic        tx_valid_i,
  input logic [31:0] tx_data_i,
  input logic        tx_ready_o,
  input logic        rx_valid_o,
  input logic [31:0] rx_data_o,
  input logic        sck_o,
  input logic [7:0]  cs_no,
  input logic        busy_o
);
  // R4
  cs_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_no));

  // R2
  sck_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> sck_o == cpol_i);

  // R9
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_i && tx_ready_o && !(blk_mode_i && tx_data_i[31] && tx_data_i[30]))
      |=> busy_o);

  // R9
  cs_steady_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(cs_no));

  // R1
  rx_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  // R5
  rx_noflag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && !blk_mode_i) |-> !rx_data_o[31]);

  // R7
  drop_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_mode_i && tx_valid_i && tx_ready_o && tx_data_i[31] && tx_data_i[30])
      |=> (&cs_no) && !busy_o && !rx_valid_o);
endmodule

bind spi_blk_master spi_blk_master_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cpol_i     (cpol_i),
  .blk_mode_i (blk_mode_i),
  .tx_valid_i (tx_valid_i),
  .tx_data_i  (tx_data_i),
  .tx_ready_o (tx_ready_o),
  .rx_valid_o (rx_valid_o),
  .rx_data_o  (rx_data_o),
  .sck_o      (sck_o),
  .cs_no      (cs_no),
  .busy_o     (busy_o)
);

// File: tb/spi_blk_master_tb.sv
`timescale 1ns/1ps
module spi_blk_master_tb;
  localparam logic [31:0] PAT = 32'hD3A5_1C6F;
  // {cpol, cpha, wsize[3:0], presc[7:0], scr[7:0], idx[2:0], data[15:0]}
  localparam logic [40:0] VEC [8] = '{
    {1'b0, 1'b0, 4'd7,  8'd0, 8'd0, 3'd0, 16'h00A5},
    {1'b0, 1'b1, 4'd15, 8'd2, 8'd0, 3'd3, 16'hBEEF},
    {1'b1, 1'b0, 4'd3,  8'd3, 8'd1, 3'd5, 16'h000B},
    {1'b1, 1'b1, 4'd0,  8'd1, 8'd2, 3'd7, 16'h0001},
    {1'b0, 1'b0, 4'd15, 8'd4, 8'd1, 3'd1, 16'h1234},
    {1'b1, 1'b1, 4'd7,  8'd0, 8'd3, 3'd6, 16'h00C3},
    {1'b0, 1'b1, 4'd11, 8'd5, 8'd0, 3'd2, 16'h09AB},
    {1'b1, 1'b0, 4'd15, 8'd0, 8'd0, 3'd4, 16'h8001}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpol = 1'b0, cpha = 1'b0, blk = 1'b0;
  logic [3:0] wsize = 4'd7;
  logic [7:0] presc = 8'd0, scr = 8'd0;
  logic [2:0] idx = 3'd0;
  logic tx_valid = 1'b0;
  logic [31:0] tx_data = '0;
  logic tx_ready, rx_valid, sck, mosi, busy;
  logic miso = 1'b0;
  logic [31:0] rx_data;
  logic [7:0] cs_n;
  logic cs_any;

  int checks = 0, fails = 0;
  int rx_n = 0, k = 0, cs_rises = 0, sck_edges = 0;
  int iv_min, iv_max;
  bit first_edge = 1'b1, done = 1'b0;
  longint last_t = 0;
  logic [31:0] rx_q [16];
  logic [15:0] slv_q [16];
  logic [15:0] slv_rx = '0;
  logic [7:0]  cs_snap = 8'hFF;

  always #4 clk = ~clk;

  spi_blk_master u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cpol_i(cpol), .cpha_i(cpha), .wsize_i(wsize),
    .presc_i(presc), .scr_i(scr), .cs_idx_i(idx), .blk_mode_i(blk),
    .tx_valid_i(tx_valid), .tx_data_i(tx_data), .tx_ready_o(tx_ready),
    .rx_valid_o(rx_valid), .rx_data_o(rx_data), .sck_o(sck), .mosi_o(mosi),
    .miso_i(miso), .cs_no(cs_n), .busy_o(busy)
  );

  assign cs_any = &cs_n;

  function automatic logic pbit(int n);
    return PAT[31 - (n % 32)];
  endfunction

  function automatic logic [31:0] pword(int off, int n);
    logic [31:0] r = '0;
    for (int i = 0; i < n; i++) r = {r[30:0], pbit(off + i)};
    return r;
  endfunction

  // slave model
  always @(negedge cs_any) begin
    k = 0; slv_rx = '0; cs_snap = cs_n;
    if (!cpha) begin miso = pbit(0); k = 1; end
  end

  always @(posedge cs_any) cs_rises++;

  always @(sck) begin
    if (!cs_any) begin
      logic lead;
      lead = (sck != cpol);
      if (lead ^ cpha) slv_rx = {slv_rx[14:0], mosi};
      else begin miso = pbit(k); k++; end
      sck_edges++;
      if (first_edge) first_edge = 1'b0;
      else begin
        int iv;
        iv = int'(($time - last_t) / 8);
        if (iv < iv_min) iv_min = iv;
        if (iv > iv_max) iv_max = iv;
      end
      last_t = $time;
    end
  end

  always @(negedge clk) begin
    if (rx_valid && rx_n < 16) begin
      rx_q[rx_n]  = rx_data;
      slv_q[rx_n] = slv_rx;
      rx_n++;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_tb();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic send(input logic [31:0] w);
    @(negedge clk);
    tx_data = w; tx_valid = 1'b1;
    first_edge = 1'b1; iv_min = 1 << 30; iv_max = 0;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_rx(input int target);
    int t = 0;
    while (rx_n < target && t < 20000) begin @(negedge clk); t++; end
    chk(rx_n >= target, "R1 word delivered", rx_n, target);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_tb();
  end

  initial begin
    int base, n, h, off;
    logic [15:0] msk;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(cs_n == 8'hFF, "R10 cs idle", cs_n, 8'hFF);
    chk(!busy && !rx_valid, "R10 busy/rx low", {busy, rx_valid}, 0);
    chk(sck == cpol, "R10 sck idle", sck, cpol);
    chk(tx_ready, "R10 ready", tx_ready, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    cs_rises = 0;

    // R1 R2 R3 R4 R5: table of single words in plain mode
    for (int v = 0; v < 8; v++) begin
      {cpol, cpha, wsize, presc, scr, idx} = VEC[v][40:16];
      @(negedge clk);
      n   = int'(wsize) + 1;
      h   = ((presc & 8'hFE) == 0 ? 1 : int'(presc & 8'hFE)) * (int'(scr) + 1);
      msk = 16'((32'd1 << n) - 1);
      base = rx_n;
      send({16'h0, VEC[v][15:0]});
      chk(busy, "R9 busy during word", busy, 1);
      wait_rx(base + 1);
      @(negedge clk);
      chk((slv_q[base] & msk) == (VEC[v][15:0] & msk), "R1 mosi word",
          slv_q[base] & msk, VEC[v][15:0] & msk);
      chk(rx_q[base] == pword(0, n), "R2 rx word", rx_q[base], pword(0, n));
      chk(iv_min == h && iv_max == h, "R3 half period", {iv_min[15:0], iv_max[15:0]}, h);
      chk(cs_snap == ~(8'd1 << idx), "R4 cs select", cs_snap, ~(8'd1 << idx));
      chk(cs_n == 8'hFF && cs_rises == v + 1, "R5 cs released per word", cs_rises, v + 1);
      chk(sck == cpol && !busy, "R2 sck back to idle", sck, cpol);
    end

    // R6 R8: three-word frame, end flag on the last
    cpol = 1'b0; cpha = 1'b1; wsize = 4'd7; presc = 8'd2; scr = 8'd0; idx = 3'd6; blk = 1'b1;
    @(negedge clk);
    cs_rises = 0; base = rx_n;
    send(32'h0000_0011);
    send(32'h0000_0022);
    wait_rx(base + 2);
    chk(cs_rises == 0 && cs_n == 8'hBF, "R6 cs held mid-frame", cs_n, 8'hBF);
    send(32'h8000_0033);
    wait_rx(base + 3);
    @(negedge clk);
    chk(cs_rises == 1 && cs_n == 8'hFF, "R6 frame closed by end flag", cs_rises, 1);
    for (int j = 0; j < 3; j++) begin
      chk(rx_q[base + j] == {(j == 0), 15'd0, pword(8 * j, 8)[15:0]}, "R8 rx word and marker",
          rx_q[base + j], {(j == 0), 15'd0, pword(8 * j, 8)[15:0]});
      chk(slv_q[base + j][7:0] == 8'(8'h11 * (j + 1)), "R6 mosi in frame",
          slv_q[base + j][7:0], 8'h11 * (j + 1));
    end

    // R7: end+drop right behind a data word
    base = rx_n; cs_rises = 0;
    send(32'h0000_0044);
    wait_rx(base + 1);
    off = sck_edges;
    send(32'hC000_0000);
    repeat (3) @(negedge clk);
    chk(rx_n == base + 1, "R7 no word from drop entry", rx_n, base + 1);
    chk(sck_edges == off, "R7 no sck edges", sck_edges, off);
    chk(cs_n == 8'hFF && cs_rises == 1, "R7 frame closed", cs_n, 8'hFF);
    chk(slv_q[base][7:0] == 8'h44, "R7 word before close", slv_q[base][7:0], 8'h44);

    // R7: end+drop with no open frame has no effect
    cs_rises = 0; off = sck_edges;
    send(32'hC000_0000);
    repeat (3) @(negedge clk);
    chk(cs_n == 8'hFF && cs_rises == 0 && !busy && rx_n == base + 1,
        "R7 idle drop ignored", cs_n, 8'hFF);

    // R7 R8: drop flag alone is data
    base = rx_n;
    send(32'h4000_0055);
    wait_rx(base + 1);
    @(negedge clk);
    chk(cs_n == 8'hBF, "R7 drop alone keeps frame", cs_n, 8'hBF);
    send(32'h8000_0066);
    wait_rx(base + 2);
    @(negedge clk);
    chk(slv_q[base][7:0] == 8'h55 && slv_q[base + 1][7:0] == 8'h66, "R7 drop alone shifted",
        {slv_q[base][7:0], slv_q[base + 1][7:0]}, 16'h5566);
    chk(rx_q[base][31] && !rx_q[base + 1][31], "R8 marker only first",
        {rx_q[base][31], rx_q[base + 1][31]}, 2'b10);
    chk(cs_n == 8'hFF, "R6 closed after end flag", cs_n, 8'hFF);

    finish_tb();
  end
endmodule